// File: doc/BRIEF.md
# Line Buffer Partition Calculator

This block works out how many lines of luma and of chroma a display scaler can keep in its line buffer. A caller pulses `start_i` with the luma viewport width, the chroma viewport width, the output rectangle width, a two-bit memory layout code and an alpha flag. The block then converts each plane's line length into six-pixel memory words. It adds up the memory banks that the layout code grants each plane and divides that total by the words per line.

The three divisions (luma, chroma, alpha) run one after another on a single restoring divider that yields one quotient bit per clock. The alpha count can lower the luma count. Both results are limited to a fixed ceiling and are presented together with a one-cycle `done_o` pulse. The results stay on the outputs until the next pulse.

Top module: `lb_part_calc`

## Requirements
- R1: The line length used for a plane is the smaller of that plane's viewport width and the output width. A line length of zero is treated as 1.
- R2: Words per line are the line length divided by 6, rounded up. The alpha plane uses the luma line length.
- R3: Memory words per plane depend on `cfg_i`:
  - Code 1 gives every plane 970.
  - Code 2 gives every plane 1290.
  - Code 3 gives luma 3712, chroma 2260 and alpha 2744.
  - Code 0 gives every plane 2744.
- R4: Each plane count is its memory words divided by its words per line, rounded down.
- R5: With `alpha_en_i` = 1 and an alpha count below the luma count, the luma result is the alpha count. With `alpha_en_i` = 0 the alpha count has no effect on the luma result.
- R6: Luma and chroma results are each limited to at most 64.
- R7: With default parameters, `done_o` is high for exactly one cycle, 43 clock edges after the edge that samples `start_i`.
- R8: While a computation is running, `start_i` and the data inputs are ignored. Neither the result nor the timing of the running computation changes.
- R9: After reset the outputs are 0 and `done_o` is 0. The outputs change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only while idle |
| luma_vp_w_i | input | 14 | Luma viewport width in pixels |
| chroma_vp_w_i | input | 14 | Chroma viewport width in pixels |
| out_rect_w_i | input | 14 | Output rectangle width in pixels |
| cfg_i | input | 2 | Memory layout code (0..3) |
| alpha_en_i | input | 1 | Alpha plane present |
| luma_lines_o | output | 7 | Luma line count, 0..64 |
| chroma_lines_o | output | 7 | Chroma line count, 0..64 |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench uses the default parameters: 14-bit widths, banks of 970, 1290 and 484 words, and a ceiling of 64. With these values the dividend is 12 bits wide and the latency is 43 edges. Because the widths span the full 14-bit range, words per line reach 2731. That makes chroma counts of zero reachable in layout 3, while very narrow lines drive every count far past the ceiling. Random widths are biased toward small values so that the alpha override and the values just either side of the ceiling occur often.

// File: rtl/lbpc_pkg.sv
package lbpc_pkg;
  // Memory layout codes; the value is what the caller drives on cfg_i.
  typedef enum logic [1:0] {
    CFG_ALL_BANKS  = 2'd0,
    CFG_BANK_A     = 2'd1,
    CFG_BANK_B     = 2'd2,
    CFG_SUBSAMPLED = 2'd3
  } lb_cfg_e;

  // Division order on the shared divider.
  typedef enum logic [1:0] {
    PL_LUMA   = 2'd0,
    PL_CHROMA = 2'd1,
    PL_ALPHA  = 2'd2
  } plane_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FINISH
  } seq_e;
endpackage

// File: rtl/lbpc_plan.sv
module lbpc_plan
  import lbpc_pkg::*;
#(
  parameter int W      = 14,
  parameter int DW     = 12,
  parameter int VW     = 12,
  parameter int BANK_A = 970,
  parameter int BANK_B = 1290,
  parameter int BANK_C = 484
) (
  input  logic [W-1:0]  luma_w_i,
  input  logic [W-1:0]  chroma_w_i,
  input  logic [W-1:0]  out_w_i,
  input  lb_cfg_e       cfg_i,
  input  plane_e        plane_i,
  output logic [DW-1:0] mem_words_o,
  output logic [VW-1:0] line_words_o
);
  localparam int MEM_ALL  = BANK_A + BANK_B + BANK_C;
  localparam int MEM_Y420 = BANK_A + BANK_B + 3 * BANK_C;
  localparam int MEM_C420 = BANK_A + BANK_B;

  // Narrower of viewport and output, never zero.
  function automatic logic [W-1:0] eff_len(input logic [W-1:0] vp, input logic [W-1:0] ow);
    logic [W-1:0] m;
    m = (vp < ow) ? vp : ow;
    if (m == '0) m = W'(1);
    return m;
  endfunction

  // Six pixels per memory word, rounded up.
  function automatic logic [VW-1:0] words_per_line(input logic [W-1:0] len);
    logic [W:0] t;
    t = {1'b0, len} + (W+1)'(5);
    return VW'(t / (W+1)'(6));
  endfunction

  function automatic logic [DW-1:0] mem_size(input lb_cfg_e c, input plane_e p);
    case (c)
      CFG_BANK_A: return DW'(BANK_A);
      CFG_BANK_B: return DW'(BANK_B);
      CFG_SUBSAMPLED: begin
        case (p)
          PL_LUMA:   return DW'(MEM_Y420);
          PL_CHROMA: return DW'(MEM_C420);
          default:   return DW'(MEM_ALL);
        endcase
      end
      default: return DW'(MEM_ALL);
    endcase
  endfunction

  logic [W-1:0] luma_len, chroma_len;

  always_comb begin
    luma_len     = eff_len(luma_w_i, out_w_i);
    chroma_len   = eff_len(chroma_w_i, out_w_i);
    line_words_o = words_per_line((plane_i == PL_CHROMA) ? chroma_len : luma_len);
    mem_words_o  = mem_size(cfg_i, plane_i);
  end
endmodule

// File: rtl/lbpc_divider.sv
module lbpc_divider #(
  parameter int DW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int RW = ((DW > VW) ? DW : VW) + 1;
  localparam int CW = $clog2(DW + 1);
  localparam int PW = DW + RW + 1;

  logic [RW-1:0] rem_q, dvs_q;
  logic [DW-1:0] quo_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  logic [RW-1:0] shifted;
  logic [RW:0]   diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q[RW-2:0], quo_q[DW-1]};
    diff    = {1'b0, shifted} - {1'b0, dvs_q};
    fits    = ~diff[RW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvd_q <= dividend_i;
        dvs_q <= RW'(divisor_i);
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? diff[RW-1:0] : shifted;
        quo_q <= {quo_q[DW-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  // R4: floor division identity holds when the quotient is handed over
  a_r4_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (PW'(quo_q) * PW'(dvs_q) + PW'(rem_q) == PW'(dvd_q)));

  // R4: remainder stays below the divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/lb_part_calc.sv
module lb_part_calc
  import lbpc_pkg::*;
#(
  parameter int W        = 14,
  parameter int BANK_A   = 970,
  parameter int BANK_B   = 1290,
  parameter int BANK_C   = 484,
  parameter int LINE_CAP = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic [W-1:0]                        luma_vp_w_i,
  input  logic [W-1:0]                        chroma_vp_w_i,
  input  logic [W-1:0]                        out_rect_w_i,
  input  logic [1:0]                          cfg_i,
  input  logic                                alpha_en_i,
  output logic [$clog2(LINE_CAP+1)-1:0]       luma_lines_o,
  output logic [$clog2(LINE_CAP+1)-1:0]       chroma_lines_o,
  output logic                                done_o
);
  localparam int MEM_MAX = BANK_A + BANK_B + 3 * BANK_C;
  localparam int DW      = $clog2(MEM_MAX + 1);
  localparam int VW      = $clog2(((2**W - 1) + 5) / 6 + 1);
  localparam int OW      = $clog2(LINE_CAP + 1);

  seq_e    state_q;
  plane_e  plane_q;
  lb_cfg_e cfg_q;
  logic [W-1:0]  vpy_q, vpc_q, ow_q;
  logic          ae_q;
  logic [DW-1:0] qy_q, qc_q, qa_q;
  logic [OW-1:0] luma_q, chroma_q;
  logic          done_q;

  logic [DW-1:0] mem_words;
  logic [VW-1:0] line_words;
  logic          div_go, div_done;
  logic [DW-1:0] div_quot;
  logic          accept_w, capture_w;
  logic [DW-1:0] luma_pick;

  function automatic logic [OW-1:0] cap(input logic [DW-1:0] q);
    if (q > DW'(LINE_CAP)) return OW'(LINE_CAP);
    return OW'(q);
  endfunction

  assign accept_w  = (state_q == ST_IDLE) && start_i;
  assign div_go    = (state_q == ST_LAUNCH);
  assign capture_w = (state_q == ST_WAIT) && div_done;
  assign luma_pick = (ae_q && (qa_q < qy_q)) ? qa_q : qy_q;

  lbpc_plan #(
    .W(W), .DW(DW), .VW(VW),
    .BANK_A(BANK_A), .BANK_B(BANK_B), .BANK_C(BANK_C)
  ) u_plan (
    .luma_w_i     (vpy_q),
    .chroma_w_i   (vpc_q),
    .out_w_i      (ow_q),
    .cfg_i        (cfg_q),
    .plane_i      (plane_q),
    .mem_words_o  (mem_words),
    .line_words_o (line_words)
  );

  lbpc_divider #(.DW(DW), .VW(VW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (div_go),
    .dividend_i (mem_words),
    .divisor_i  (line_words),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      plane_q  <= PL_LUMA;
      cfg_q    <= CFG_ALL_BANKS;
      vpy_q    <= '0;
      vpc_q    <= '0;
      ow_q     <= '0;
      ae_q     <= 1'b0;
      qy_q     <= '0;
      qc_q     <= '0;
      qa_q     <= '0;
      luma_q   <= '0;
      chroma_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            vpy_q   <= luma_vp_w_i;
            vpc_q   <= chroma_vp_w_i;
            ow_q    <= out_rect_w_i;
            cfg_q   <= lb_cfg_e'(cfg_i);
            ae_q    <= alpha_en_i;
            plane_q <= PL_LUMA;
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (capture_w) begin
            case (plane_q)
              PL_LUMA:   qy_q <= div_quot;
              PL_CHROMA: qc_q <= div_quot;
              default:   qa_q <= div_quot;
            endcase
            if (plane_q == PL_ALPHA) begin
              state_q <= ST_FINISH;
            end else begin
              plane_q <= plane_e'(plane_q + 2'd1);
              state_q <= ST_LAUNCH;
            end
          end
        end
        default: begin
          luma_q   <= cap(luma_pick);
          chroma_q <= cap(qc_q);
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign luma_lines_o   = luma_q;
  assign chroma_lines_o = chroma_q;
  assign done_o         = done_q;

  // R6: both results respect the ceiling
  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (luma_lines_o <= OW'(LINE_CAP)) && (chroma_lines_o <= OW'(LINE_CAP)));

  // R5: with alpha present the luma result never exceeds the capped alpha count
  a_r5_alpha_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ae_q) |-> (luma_lines_o <= cap(qa_q)));

  // R7: strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: latched request stays frozen while busy
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(vpy_q) && $stable(vpc_q) && $stable(ow_q)
                             && $stable(cfg_q) && $stable(ae_q));

  // R9: results move only together with the strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(luma_lines_o) && $stable(chroma_lines_o));
endmodule

// File: tb/lb_part_calc_test.sv
module lb_part_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 43;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [13:0] luma_vp_w_i = '0, chroma_vp_w_i = '0, out_rect_w_i = '0;
  logic [1:0] cfg_i = '0;
  logic       alpha_en_i = 1'b0;
  logic [6:0] luma_lines_o, chroma_lines_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  int prev_ly = 0, prev_lc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb_part_calc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .luma_vp_w_i(luma_vp_w_i), .chroma_vp_w_i(chroma_vp_w_i),
    .out_rect_w_i(out_rect_w_i), .cfg_i(cfg_i), .alpha_en_i(alpha_en_i),
    .luma_lines_o(luma_lines_o), .chroma_lines_o(chroma_lines_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Restatement of the requirements as plain integer arithmetic.
  function automatic void model(input int vy, input int vc, input int ow, input int cfg,
                                input int ae, output int ly, output int lc);
    int len_y, len_c, wy, wc, my, mc, ma, py, pc, pa;
    len_y = (ow < vy) ? ow : vy;
    len_c = (ow < vc) ? ow : vc;
    if (len_y < 1) len_y = 1;
    if (len_c < 1) len_c = 1;
    wy = len_y / 6 + ((len_y % 6) != 0 ? 1 : 0);
    wc = len_c / 6 + ((len_c % 6) != 0 ? 1 : 0);
    case (cfg)
      1: begin my = 970;  mc = 970;  ma = 970;  end
      2: begin my = 1290; mc = 1290; ma = 1290; end
      3: begin my = 3712; mc = 2260; ma = 2744; end
      default: begin my = 2744; mc = 2744; ma = 2744; end
    endcase
    py = my / wy;
    pc = mc / wc;
    pa = ma / wy;
    if (ae != 0 && pa < py) py = pa;
    ly = (py > 64) ? 64 : py;
    lc = (pc > 64) ? 64 : pc;
  endfunction

  task automatic run_case(input int vy, input int vc, input int ow, input int cfg,
                          input int ae, input bit disturb, input string req);
    int ly, lc, lat;
    model(vy, vc, ow, cfg, ae, ly, lc);
    @(negedge clk);
    luma_vp_w_i = 14'(vy); chroma_vp_w_i = 14'(vc); out_rect_w_i = 14'(ow);
    cfg_i = 2'(cfg); alpha_en_i = 1'(ae); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(posedge clk); #1;
      lat++;
      if (disturb && lat == 5) begin
        start_i = 1'b1;
        luma_vp_w_i = 14'(vy ^ 14'h155); chroma_vp_w_i = 14'd3;
        out_rect_w_i = 14'd9; cfg_i = 2'(cfg + 1); alpha_en_i = ~1'(ae);
      end
      if (disturb && lat == 6) start_i = 1'b0;
      if (lat == 20) begin
        // R9: previous results held during a new computation
        check(luma_lines_o == 7'(prev_ly), "R9 luma hold", int'(luma_lines_o), prev_ly);
        check(chroma_lines_o == 7'(prev_lc), "R9 chroma hold", int'(chroma_lines_o), prev_lc);
      end
    end
    check(lat == EXP_LAT, disturb ? "R8 latency under disturbance" : "R7 latency", lat, EXP_LAT);
    check(int'(luma_lines_o) == ly, req, int'(luma_lines_o), ly);
    check(int'(chroma_lines_o) == lc, req, int'(chroma_lines_o), lc);
    @(posedge clk); #1;
    check(done_o == 1'b0, "R7 single-cycle strobe", int'(done_o), 0);
    prev_ly = ly;
    prev_lc = lc;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(luma_lines_o == '0, "R9 reset luma", int'(luma_lines_o), 0);
    check(chroma_lines_o == '0, "R9 reset chroma", int'(chroma_lines_o), 0);
    check(done_o == 1'b0, "R9 reset strobe", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1: narrower width wins; zero becomes 1
    run_case(3000, 3000, 1200, 1, 0, 1'b0, "R1 min of viewport and output");
    run_case(1200, 1200, 3000, 1, 0, 1'b0, "R1 viewport narrower");
    run_case(0, 0, 500, 2, 0, 1'b0, "R1 zero length");
    run_case(700, 700, 0, 0, 1, 1'b0, "R1 zero output width");
    // R2: round-up of words per line, alpha follows luma length
    run_case(1940, 1940, 4000, 1, 0, 1'b0, "R2 ceil rounding");
    run_case(1938, 1938, 4000, 1, 0, 1'b0, "R2 exact multiple");
    // R3: every layout code
    for (int c = 0; c < 4; c++) begin
      run_case(3000, 3000, 3000, c, 0, 1'b0, "R3 layout sizes");
      run_case(3000, 1500, 3000, c, 1, 1'b0, "R3 layout sizes with alpha");
    end
    // R4: floor of quotients at large widths
    run_case(16383, 16383, 16383, 3, 1, 1'b0, "R4 widest lines");
    run_case(2905, 2905, 2905, 2, 0, 1'b0, "R4 floor division");
    // R5: alpha override on and off
    run_case(1940, 600, 4000, 3, 1, 1'b0, "R5 alpha lowers luma");
    run_case(1940, 600, 4000, 3, 0, 1'b0, "R5 alpha disabled");
    // R6: ceiling boundary
    run_case(252, 252, 4000, 0, 0, 1'b0, "R6 just over ceiling");
    run_case(258, 258, 4000, 0, 0, 1'b0, "R6 just under ceiling");
    run_case(1, 1, 1, 3, 1, 1'b0, "R6 tiny lines");
    // R8: start and inputs toggled mid-computation
    run_case(1940, 600, 4000, 3, 1, 1'b1, "R8 start ignored while busy");
    run_case(500, 5000, 800, 0, 0, 1'b1, "R8 start ignored while busy");

    for (int i = 0; i < 300; i++) begin
      int vy, vc, ow;
      if (($urandom % 4) == 0) begin
        vy = $urandom_range(0, 16383); vc = $urandom_range(0, 16383);
        ow = $urandom_range(0, 16383);
      end else begin
        vy = $urandom_range(0, 800); vc = $urandom_range(0, 800);
        ow = $urandom_range(0, 900);
      end
      run_case(vy, vc, ow, int'($urandom % 4), int'($urandom % 2), (($urandom % 8) == 0),
               "R1/R2/R3/R4/R5/R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule